// File: doc/BRIEF.md
# Bit-Band Alias Address Translator

This block sits between a bus master and a word-wide memory or register bank that answers a read in the cycle after the request. Two backing regions of 1 MiB each are given a 32 MiB alias window. In that window every word stands for exactly one bit of the backing region. An access that falls in an alias window becomes a single-bit operation on the backing word. All other accesses reach the memory port unchanged, in the same cycle.

An alias read fetches the backing word and returns the chosen bit in bit 0 of the response, with zeros everywhere else. An alias write is an atomic read-modify-write. The translator first reads the backing word and stalls the master for one cycle. It then writes back the word with only the addressed bit replaced by bit 0 of the write data. Because the master is held off while this happens, no other access can reach the memory between the read and the write.

Top module: `bitband_xlate`

## Requirements
- R1: While reset is held, and after it is released with no request, `up_ready` is 1, `up_rvalid` is 0 and `mem_req` is 0.
- R2: An access outside both alias windows appears on the memory port in the same cycle with the same address, direction and write data, and is never stalled. A read response arrives on `up_rvalid`/`up_rdata` one cycle after the read is accepted and equals `mem_rdata`.
- R3: The alias windows are 0x2200_0000–0x23FF_FFFF and 0x4200_0000–0x43FF_FFFF. Addresses next to them, such as 0x21FF_FFFC, 0x2400_0000 and the backing regions themselves, are passed through.
- R4: For an alias address A in a window whose backing base is B (0x2000_0000 or 0x4000_0000), the backing word is B + 4·A[24:7] and the bit within that little-endian word is A[6:2] (byte lane × 8 + bit number). For example, 0x2200_6008 selects bit 2 of the word at 0x2000_0300, and 0x23FF_FFFC selects bit 31 of 0x200F_FFFC.
- R5: An alias read is never stalled. One cycle after it is accepted it returns {31'b0, selected bit}.
- R6: An alias write holds `up_ready` low for exactly one cycle, during which the backing word is read. In the next cycle that word is written back with only the selected bit replaced.
- R7: The new bit value of an alias write is bit 0 of the write data. Bits 31:1 of the write data have no effect.
- R8: Address bits 1:0 of an alias access are ignored.
- R9: Between the read and the write-back of an alias write, no other access reaches the memory port, and the write-back goes to the word that was read.
- R10: The peripheral window behaves exactly like the memory window, relative to its own backing base 0x4000_0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| up_req | input | 1 | Master request; must stay stable while `up_ready` is 0 |
| up_we | input | 1 | Master request is a write |
| up_addr | input | 32 | Master byte address |
| up_wdata | input | 32 | Master write data |
| up_ready | output | 1 | Request accepted in this cycle when high |
| up_rvalid | output | 1 | Read response valid |
| up_rdata | output | 32 | Read response data |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid the cycle after a read request |

## Verification
The bench works on bit positions at the ends of a word and of a window: lane 0 bits 2 and 4, lane 1 bit 11, lane 3 bits 30 and 31, and the last alias word of the memory window. A design that swapped the lane order or dropped a carry in the offset would return the wrong bit or change the wrong word. It drives alias writes whose upper data bits are the inverse of bit 0, and alias addresses with bits 1:0 set, so a design that used the wrong data bit or decoded those address bits would flip the wrong bit. It issues writes just outside each window, which a loose window compare would turn into single-bit writes that corrupt the stored pattern. It also places a read of the same word right after an alias write, and counts stall cycles for every access. A design that let a request slip between the read and the write-back, or stalled plain traffic, is caught by the stall count or by the read-back value.

// File: rtl/bb_pkg.sv
package bb_pkg;
  localparam int unsigned ADDR_W    = 32;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned BIT_IDX_W = $clog2(DATA_W);

  typedef enum logic [0:0] {
    ST_PASS   = 1'b0,
    ST_MODIFY = 1'b1
  } bb_state_e;

  typedef struct packed {
    logic                 hit;
    logic [ADDR_W-1:0]    word_addr;
    logic [BIT_IDX_W-1:0] bit_idx;
  } bb_xlate_t;
endpackage

// File: rtl/bb_alias_decode.sv
module bb_alias_decode
  import bb_pkg::*;
#(
  parameter logic [ADDR_W-1:0] BASE        = 32'h2000_0000,
  parameter logic [ADDR_W-1:0] ALIAS_OFS   = 32'h0200_0000,
  parameter int unsigned       REGION_BITS = 20
) (
  input  logic [ADDR_W-1:2] addr_i,
  output bb_xlate_t         xl_o
);
  // each backing byte owns 8 bits x 4 alias bytes
  localparam int unsigned BYTE_SPAN_W = $clog2(8 * 4);
  localparam int unsigned SPAN_W      = REGION_BITS + BYTE_SPAN_W;
  localparam int unsigned LANE_LSB    = BYTE_SPAN_W + 2;
  localparam logic [ADDR_W-1:0] ALIAS_BASE = BASE + ALIAS_OFS;

  always_comb begin
    xl_o.hit       = (addr_i[ADDR_W-1:SPAN_W] == ALIAS_BASE[ADDR_W-1:SPAN_W]);
    xl_o.word_addr = {BASE[ADDR_W-1:REGION_BITS], addr_i[SPAN_W-1:LANE_LSB], 2'b00};
    xl_o.bit_idx   = addr_i[LANE_LSB-1:2];
  end
endmodule

// File: rtl/bb_bit_lane.sv
module bb_bit_lane
  import bb_pkg::*;
(
  input  logic [DATA_W-1:0]    word_i,
  input  logic [BIT_IDX_W-1:0] idx_i,
  input  logic                 val_i,
  output logic [DATA_W-1:0]    merged_o,
  output logic                 pick_o
);
  always_comb begin
    merged_o        = word_i;
    merged_o[idx_i] = val_i;
    pick_o          = word_i[idx_i];
  end
endmodule

// File: rtl/bb_rmw_ctrl.sv
module bb_rmw_ctrl
  import bb_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 up_req_i,
  input  logic                 up_we_i,
  input  logic [ADDR_W-1:0]    up_addr_i,
  input  logic [DATA_W-1:0]    up_wdata_i,
  input  bb_xlate_t            xl_i,
  input  logic [DATA_W-1:0]    merged_i,
  output logic                 up_ready_o,
  output logic                 rsp_valid_o,
  output logic                 rsp_alias_o,
  output logic [BIT_IDX_W-1:0] lane_idx_o,
  output logic                 lane_val_o,
  output logic                 mem_req_o,
  output logic                 mem_we_o,
  output logic [ADDR_W-1:0]    mem_addr_o,
  output logic [DATA_W-1:0]    mem_wdata_o
);
  bb_state_e            state_q, state_d;
  logic [ADDR_W-1:0]    hold_addr_q;
  logic [BIT_IDX_W-1:0] hold_bit_q;
  logic                 hold_val_q;
  logic                 hold_en;
  logic                 rsp_valid_q, rsp_valid_d;
  logic                 rsp_alias_q, rsp_alias_d;
  logic [BIT_IDX_W-1:0] rsp_bit_q, rsp_bit_d;
  logic                 accept;

  always_comb begin
    state_d     = state_q;
    hold_en     = 1'b0;
    up_ready_o  = 1'b1;
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = up_addr_i;
    mem_wdata_o = up_wdata_i;
    unique case (state_q)
      ST_PASS: begin
        mem_req_o  = up_req_i;
        mem_we_o   = up_we_i & ~xl_i.hit;
        mem_addr_o = xl_i.hit ? xl_i.word_addr : up_addr_i;
        if (up_req_i && up_we_i && xl_i.hit) begin
          up_ready_o = 1'b0;
          hold_en    = 1'b1;
          state_d    = ST_MODIFY;
        end
      end
      ST_MODIFY: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = hold_addr_q;
        mem_wdata_o = merged_i;
        state_d     = ST_PASS;
      end
      default: state_d = ST_PASS;
    endcase
    accept      = up_req_i & up_ready_o;
    rsp_valid_d = accept & ~up_we_i;
    rsp_alias_d = xl_i.hit;
    rsp_bit_d   = xl_i.bit_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_PASS;
      hold_addr_q <= '0;
      hold_bit_q  <= '0;
      hold_val_q  <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_alias_q <= 1'b0;
      rsp_bit_q   <= '0;
    end else begin
      state_q     <= state_d;
      rsp_valid_q <= rsp_valid_d;
      if (rsp_valid_d) begin
        rsp_alias_q <= rsp_alias_d;
        rsp_bit_q   <= rsp_bit_d;
      end
      if (hold_en) begin
        hold_addr_q <= xl_i.word_addr;
        hold_bit_q  <= xl_i.bit_idx;
        hold_val_q  <= up_wdata_i[0];
      end
    end
  end

  // no response is pending while a write-back is in flight, so one lane serves both
  assign lane_idx_o  = (state_q == ST_MODIFY) ? hold_bit_q : rsp_bit_q;
  assign lane_val_o  = hold_val_q;
  assign rsp_valid_o = rsp_valid_q;
  assign rsp_alias_o = rsp_alias_q;

  // R6
  stall_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !up_ready_o |=> up_ready_o);

  // R9
  rmw_same_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_we_o && !up_ready_o) |=>
      (mem_req_o && mem_we_o && mem_addr_o == $past(mem_addr_o)));

  // R5
  read_resp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_req_i && up_ready_o && !up_we_i) |=> rsp_valid_o);
endmodule

// File: rtl/bitband_xlate.sv
module bitband_xlate
  import bb_pkg::*;
#(
  parameter int unsigned                  NUM_REGIONS  = 2,
  parameter int unsigned                  REGION_BITS  = 20,
  parameter logic [ADDR_W-1:0]            ALIAS_OFS    = 32'h0200_0000,
  parameter logic [NUM_REGIONS*ADDR_W-1:0] REGION_BASES = {32'h4000_0000, 32'h2000_0000}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_req,
  input  logic              up_we,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic [DATA_W-1:0] up_wdata,
  output logic              up_ready,
  output logic              up_rvalid,
  output logic [DATA_W-1:0] up_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  logic [1:0]           rst_sync_q;
  logic                 core_rst_n;
  bb_xlate_t            dec_xl [NUM_REGIONS];
  bb_xlate_t            sel_xl;
  logic [DATA_W-1:0]    merged;
  logic                 picked;
  logic [BIT_IDX_W-1:0] lane_idx;
  logic                 lane_val;
  logic                 rsp_alias;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : gen_region
    bb_alias_decode #(
      .BASE        (REGION_BASES[r*ADDR_W +: ADDR_W]),
      .ALIAS_OFS   (ALIAS_OFS),
      .REGION_BITS (REGION_BITS)
    ) u_dec (
      .addr_i (up_addr[ADDR_W-1:2]),
      .xl_o   (dec_xl[r])
    );
  end

  always_comb begin
    sel_xl = '0;
    for (int r = 0; r < NUM_REGIONS; r++) begin
      if (dec_xl[r].hit) sel_xl = dec_xl[r];
    end
  end

  bb_rmw_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (core_rst_n),
    .up_req_i    (up_req),
    .up_we_i     (up_we),
    .up_addr_i   (up_addr),
    .up_wdata_i  (up_wdata),
    .xl_i        (sel_xl),
    .merged_i    (merged),
    .up_ready_o  (up_ready),
    .rsp_valid_o (up_rvalid),
    .rsp_alias_o (rsp_alias),
    .lane_idx_o  (lane_idx),
    .lane_val_o  (lane_val),
    .mem_req_o   (mem_req),
    .mem_we_o    (mem_we),
    .mem_addr_o  (mem_addr),
    .mem_wdata_o (mem_wdata)
  );

  bb_bit_lane u_lane (
    .word_i   (mem_rdata),
    .idx_i    (lane_idx),
    .val_i    (lane_val),
    .merged_o (merged),
    .pick_o   (picked)
  );

  assign up_rdata = rsp_alias ? {{(DATA_W-1){1'b0}}, picked} : mem_rdata;

  // R2
  passthrough_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    (up_req && up_ready && !sel_xl.hit) |->
      (mem_req && mem_we == up_we && mem_addr == up_addr && mem_wdata == up_wdata));

  // R5
  alias_rdata_upper_zero_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    (up_rvalid && rsp_alias) |-> (up_rdata[DATA_W-1:1] == '0));
endmodule

// File: tb/bitband_xlate_tb_top.sv
`timescale 1ns/1ps
module bitband_xlate_tb_top;
  logic        clk;
  logic        rst_n;
  logic        up_req, up_we;
  logic [31:0] up_addr, up_wdata;
  logic        up_ready, up_rvalid;
  logic [31:0] up_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit mon_on = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] mem [logic [31:0]];

  initial clk = 1'b0;
  always #4 clk = ~clk;

  bitband_xlate dut_i (
    .clk(clk), .rst_n(rst_n),
    .up_req(up_req), .up_we(up_we), .up_addr(up_addr), .up_wdata(up_wdata),
    .up_ready(up_ready), .up_rvalid(up_rvalid), .up_rdata(up_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) mem[mem_addr] = mem_wdata;
      else        mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // monitor: pops one expected item per response
  always @(negedge clk) begin
    if (mon_on) begin
      if (up_rvalid) begin
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R2 actual=unexpected_response expected=none");
        end else begin
          automatic logic [31:0] e = exp_q.pop_front();
          automatic string t = tag_q.pop_front();
          chk(t, up_rdata, e);
        end
      end else if (exp_q.size() != 0) begin
        checks++; errors++;
        $display("FAIL %s actual=no_response expected=response_one_cycle_after_accept", tag_q[0]);
        void'(exp_q.pop_front());
        void'(tag_q.pop_front());
      end
    end
  end

  task automatic access(input logic we, input logic [31:0] addr, input logic [31:0] wdata,
                        input logic [31:0] expd, input int exp_stall, input string tag);
    int stalls = 0;
    @(negedge clk);
    up_req = 1'b1; up_we = we; up_addr = addr; up_wdata = wdata;
    #1;
    while (!up_ready) begin
      stalls++;
      @(negedge clk);
      #1;
    end
    if (!we) begin
      exp_q.push_back(expd);
      tag_q.push_back(tag);
    end
    @(posedge clk);
    #1;
    up_req = 1'b0;
    chk({tag, " stall"}, stalls, exp_stall);
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d, input int st, input string t);
    access(1'b1, a, d, 32'h0, st, t);
  endtask

  task automatic rd(input logic [31:0] a, input logic [31:0] e, input string t);
    access(1'b0, a, 32'h0, e, 0, t);
  endtask

  initial begin
    rst_n = 1'b0; up_req = 1'b0; up_we = 1'b0; up_addr = '0; up_wdata = '0;
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", up_ready, 1'b1);
    chk("R1 rvalid in reset", up_rvalid, 1'b0);
    chk("R1 mem_req in reset", mem_req, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 ready idle", up_ready, 1'b1);
    chk("R1 rvalid idle", up_rvalid, 1'b0);
    chk("R1 mem_req idle", mem_req, 1'b0);
    mon_on = 1'b1;

    // R2 plain traffic
    wr(32'h2000_0300, 32'hA5A5_0F0F, 0, "R2 plain write");
    rd(32'h2000_0300, 32'hA5A5_0F0F, "R2 plain read");
    // R4 R5 alias reads across lanes
    rd(32'h2200_6008, 32'h1, "R4 lane0 bit2");
    rd(32'h2200_6010, 32'h0, "R5 lane0 bit4");
    rd(32'h2200_602C, 32'h1, "R4 lane1 bit3");
    rd(32'h2200_607C, 32'h1, "R4 lane3 bit7");
    rd(32'h2200_6078, 32'h0, "R5 lane3 bit6");
    // R6 set one bit, read back right after
    wr(32'h2200_6010, 32'h0000_0001, 1, "R6 alias set");
    rd(32'h2000_0300, 32'hA5A5_0F1F, "R9 word after set");
    // R7 upper write data ignored
    wr(32'h2200_607C, 32'hFFFF_FFFE, 1, "R7 alias clear");
    rd(32'h2000_0300, 32'h25A5_0F1F, "R7 word after clear");
    // R8 low address bits ignored
    wr(32'h2200_600B, 32'h0000_0000, 1, "R8 alias misaligned");
    rd(32'h2000_0300, 32'h25A5_0F1B, "R8 word after write");
    rd(32'h2200_6009, 32'h0, "R8 alias read misaligned");
    // R10 peripheral window
    wr(32'h4000_1000, 32'h0000_0000, 0, "R10 plain write");
    wr(32'h4202_0054, 32'h0000_0001, 1, "R10 alias set");
    rd(32'h4000_1000, 32'h0020_0000, "R10 word after set");
    rd(32'h4202_0054, 32'h1, "R10 alias read");
    // R4 last alias word of memory window
    wr(32'h200F_FFFC, 32'h7FFF_FFFF, 0, "R4 top plain write");
    wr(32'h23FF_FFFC, 32'hFFFF_FFFF, 1, "R4 top alias set");
    rd(32'h200F_FFFC, 32'hFFFF_FFFF, "R4 top word");
    // R3 neighbours pass through
    wr(32'h2400_0000, 32'h1234_5678, 0, "R3 above window write");
    rd(32'h2400_0000, 32'h1234_5678, "R3 above window read");
    wr(32'h21FF_FFFC, 32'hCAFE_F00D, 0, "R3 below window write");
    rd(32'h21FF_FFFC, 32'hCAFE_F00D, "R3 below window read");
    rd(32'h2000_0300, 32'h25A5_0F1B, "R3 backing untouched");

    repeat (3) @(negedge clk);
    chk("R2 responses drained", exp_q.size(), 0);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule